// File: doc/BRIEF.md
# Long-Press Reset Pulse Timer

This block turns a deliberate long press of a push button into one system reset pulse. It watches an active-low button input and counts clock cycles while the button stays pressed. Only after the press has lasted a full hold time does it drive its active-low reset output low. The output then stays low for a fixed recovery time and goes high again, whatever the button does in the meantime. A short press changes nothing. A press that is still held after the pulse cannot start a second pulse until the button has been released.

A mode input acts as a strap. Its value is captured right after reset. While the button is released, the captured flag follows the input. While the button is pressed, the flag does not change. With the flag set, the hold delay is removed: the pulse starts as soon as the synchronized button reads low. The button input passes through a two-stage synchronizer. The asynchronous reset is released synchronously. Hold time and recovery time are parameters counted in clock cycles.

Top module: `lp_reset_timer`

## Requirements
- R1: While `rst_n_i` is low, and after its release with the button released, `rst_out_n_o` is high.
- R2: Normal mode: when `btn_n_i` is sampled low on HOLD_CYC or more consecutive rising edges, `rst_out_n_o` goes low directly after rising edge number HOLD_CYC+2. Edge number 1 is the first edge that samples the button low.
- R3: Normal mode: a press shorter than HOLD_CYC edges leaves `rst_out_n_o` high. A release of even one sampled edge clears the count, so a new press needs the full HOLD_CYC again.
- R4: Every reset pulse keeps `rst_out_n_o` low for exactly PULSE_CYC consecutive cycles. This holds whether the button is released or held during the pulse.
- R5: One continuous press gives at most one pulse. After a pulse, a new pulse can start only after the button has read high.
- R6: Test mode: `rst_out_n_o` goes low directly after rising edge 3 of a press, counted as in R2, even for a press of one edge.
- R7: The mode flag takes the value of `mode_sel_i` on the first clock edge after reset is released. A value of 1 selects test mode and 0 selects normal mode.
- R8: While the synchronized button reads high, the mode flag follows `mode_sel_i`. While it reads low, changes of `mode_sel_i` are ignored, and a pulse in progress keeps the timing of the mode it started in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_n_i | input | 1 | Push button, low while pressed |
| mode_sel_i | input | 1 | Mode strap, 1 selects zero-delay test mode |
| rst_out_n_o | output | 1 | Reset pulse output, active low |

## Verification
The checker verifies on every cycle of any run the following behaviours:
- each low output stretch lasts exactly PULSE_CYC cycles;
- in normal mode the output falls only after at least HOLD_CYC consecutive low samples of the synchronized button;
- no second pulse starts before a release;
- the mode flag is frozen while the button is low;
- the flag loads the strap after reset.

Only the bench scenarios can show the rest:
- the exact edge at which the pulse starts relative to the raw pin, including the synchronizer latency;
- that a press just short of the threshold does nothing;
- that a one-cycle release restarts the count;
- that a mode change during a press does not shorten the hold.

// File: rtl/lprt_pkg.sv
package lprt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_PULSE = 2'd2,
    ST_WAIT  = 2'd3
  } lprt_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lprt_sync.sv
module lprt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sh_q <= RST_VAL;
        else          sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sh_q <= {STAGES{RST_VAL}};
        else          sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/lprt_mode.sv
module lprt_mode (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sel_i,
  input  logic btn_hi_i,
  output logic mode_o,
  output logic primed_o
);

  logic mode_q;
  logic primed_q;
  logic load_en;

  // first cycle after reset captures the strap; afterwards only while released
  assign load_en = ~primed_q | btn_hi_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      if (load_en) mode_q <= sel_i;
    end
  end

  assign mode_o   = mode_q;
  assign primed_o = primed_q;

endmodule

// File: rtl/lprt_fsm.sv
module lprt_fsm
  import lprt_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 1250000000,
  parameter int unsigned PULSE_CYC = 66250000
) (
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        btn_hi_i,
  input  logic        test_i,
  output lprt_state_e state_o,
  output logic        rst_n_o
);

  localparam int unsigned MAXC = max_u(HOLD_CYC, PULSE_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] ONE        = CW'(1);

  lprt_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (!btn_hi_i) begin
          if (test_i || (HOLD_CYC == 1)) begin
            state_d = ST_PULSE;
          end else begin
            state_d = ST_COUNT;
            cnt_d   = ONE;
          end
        end
      end
      ST_COUNT: begin
        if (btn_hi_i) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (test_i || (cnt_q == HOLD_LAST)) begin
          state_d = ST_PULSE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_PULSE: begin
        if (cnt_q == PULSE_LAST) begin
          cnt_d   = '0;
          state_d = btn_hi_i ? ST_IDLE : ST_WAIT;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_WAIT: begin
        if (btn_hi_i) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign rst_n_o = (state_q != ST_PULSE);

endmodule

// File: rtl/lp_reset_timer.sv
module lp_reset_timer
  import lprt_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = 1250000000,
  parameter int unsigned PULSE_CYC   = 66250000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic btn_n_i,
  input  logic mode_sel_i,
  output logic rst_out_n_o
);

  logic        rst_sync_n;
  logic        btn_hi;
  logic        test_mode;
  logic        mode_primed;
  lprt_state_e fsm_state;

  lprt_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rsync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (1'b1),
    .q_o     (rst_sync_n)
  );

  lprt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bsync (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .d_i     (btn_n_i),
    .q_o     (btn_hi)
  );

  lprt_mode u_mode (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_n),
    .sel_i    (mode_sel_i),
    .btn_hi_i (btn_hi),
    .mode_o   (test_mode),
    .primed_o (mode_primed)
  );

  lprt_fsm #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) u_fsm (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_n),
    .btn_hi_i (btn_hi),
    .test_i   (test_mode),
    .state_o  (fsm_state),
    .rst_n_o  (rst_out_n_o)
  );

endmodule

// File: rtl/lprt_chk.sv
module lprt_chk
  import lprt_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 1250000000,
  parameter int unsigned PULSE_CYC = 66250000
) (
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        btn_hi_i,
  input  logic        mode_sel_i,
  input  logic        mode_i,
  input  logic        primed_i,
  input  lprt_state_e state_i,
  input  logic        out_n_i
);

  localparam int unsigned MAXC = max_u(HOLD_CYC, PULSE_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SAT   = CW'(MAXC);
  localparam logic [CW-1:0] HOLDV = CW'(HOLD_CYC);
  localparam logic [CW-1:0] PULV  = CW'(PULSE_CYC);

  logic [CW-1:0] low_run;
  logic [CW-1:0] btn_run;
  logic          seen_high;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      low_run   <= '0;
      btn_run   <= '0;
      seen_high <= 1'b1;
    end else begin
      if (out_n_i)              low_run <= '0;
      else if (low_run != SAT)  low_run <= low_run + CW'(1);
      if (btn_hi_i)             btn_run <= '0;
      else if (btn_run != SAT)  btn_run <= btn_run + CW'(1);
      if (btn_hi_i)             seen_high <= 1'b1;
      else if (!out_n_i)        seen_high <= 1'b0;
    end
  end

  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(out_n_i) |-> (low_run == PULV));

  assert_pulse_max_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !out_n_i |-> (low_run < PULV));

  assert_hold_met_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($fell(out_n_i) && !mode_i) |-> (btn_run >= HOLDV));

  assert_press_seen_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(out_n_i) |-> (btn_run != '0));

  assert_one_per_press_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(out_n_i) |-> seen_high);

  assert_wait_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_i == ST_WAIT && btn_hi_i) |=> (state_i == ST_IDLE));

  assert_mode_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (primed_i && !btn_hi_i) |=> $stable(mode_i));

  assert_strap_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(primed_i) |-> (mode_i == $past(mode_sel_i)));

endmodule

bind lp_reset_timer lprt_chk #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_sync_n),
  .btn_hi_i   (btn_hi),
  .mode_sel_i (mode_sel_i),
  .mode_i     (test_mode),
  .primed_i   (mode_primed),
  .state_i    (fsm_state),
  .out_n_i    (rst_out_n_o)
);

// File: tb/sim_lp_reset_timer.sv
module sim_lp_reset_timer;

  localparam int HOLD  = 5;
  localparam int PULSE = 4;

  logic clk;
  logic rst_n;
  logic btn_n;
  logic mode_sel;
  logic out_n;

  int total;
  int bad;

  lp_reset_timer #(.HOLD_CYC(HOLD), .PULSE_CYC(PULSE), .SYNC_STAGES(2)) u0 (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .btn_n_i     (btn_n),
    .mode_sel_i  (mode_sel),
    .rst_out_n_o (out_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic msel);
    @(negedge clk);
    mode_sel = msel;
    btn_n    = 1'b1;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 output during reset", int'(out_n), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 output after reset", int'(out_n), 1);
  endtask

  // negedge i drives the level seen at rising edge i+1; output sampled at negedge i
  task automatic press(input int len, input int gap, input int len2, input int msel_at,
                       output int first, output int lows, output int falls);
    int win;
    logic prev;
    win   = len + gap + len2 + HOLD + PULSE + 8;
    prev  = 1'b1;
    first = -1;
    lows  = 0;
    falls = 0;
    for (int i = 0; i <= win; i++) begin
      if (i > 0) begin
        if (!out_n) begin
          lows++;
          if (first < 0) first = i;
          if (prev) falls++;
        end
        prev = out_n;
      end
      if (i == msel_at) mode_sel = 1'b1;
      btn_n = ((i < len) || (i >= len + gap && i < len + gap + len2)) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    btn_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f, l, n;
    total    = 0;
    bad      = 0;
    rst_n    = 1'b0;
    btn_n    = 1'b1;
    mode_sel = 1'b0;

    // normal mode, sweep of press lengths across and past the threshold
    do_reset(1'b0);
    for (int len = 1; len <= HOLD + PULSE + 4; len++) begin
      press(len, 0, 0, -1, f, l, n);
      if (len >= HOLD) begin
        chk($sformatf("R2 start edge len=%0d", len), f, HOLD + 2);
        chk($sformatf("R4 width len=%0d", len), l, PULSE);
        chk($sformatf("R5 single pulse len=%0d", len), n, 1);
      end else begin
        chk($sformatf("R3 short press len=%0d", len), n, 0);
        chk($sformatf("R3 output high len=%0d", len), l, 0);
      end
    end

    // R3: a one-edge release clears the count
    press(HOLD - 1, 1, HOLD - 1, -1, f, l, n);
    chk("R3 split press no pulse", n, 0);
    press(HOLD - 1, 1, HOLD, -1, f, l, n);
    chk("R3 count restarts after gap", f, 2 * HOLD + 2);
    chk("R4 width after restart", l, PULSE);

    // R8: strap raised mid-press is ignored until release
    press(HOLD + 1, 0, 0, 3, f, l, n);
    chk("R8 change while pressed ignored", f, HOLD + 2);
    press(1, 0, 0, -1, f, l, n);
    chk("R8 change accepted while released", f, 3);
    chk("R4 width test mode after change", l, PULSE);
    mode_sel = 1'b0;
    repeat (4) @(negedge clk);
    press(1, 0, 0, -1, f, l, n);
    chk("R8 return to normal mode", n, 0);

    // R7, R6: strap high at power-up selects zero-delay mode
    do_reset(1'b1);
    for (int len = 1; len <= 3; len++) begin
      press(len, 0, 0, -1, f, l, n);
      chk($sformatf("R7 R6 immediate start len=%0d", len), f, 3);
      chk($sformatf("R4 width test len=%0d", len), l, PULSE);
    end
    press(PULSE + 6, 0, 0, -1, f, l, n);
    chk("R5 held press test mode single pulse", n, 1);
    chk("R4 width held test mode", l, PULSE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule